// File: doc/BRIEF.md
# Electronic Shutter Exposure Timer

This block sets the exposure of a CCD image sensor by deciding, field by field, which lines get a substrate charge-discharge pulse and which fields end with a readout gate pulse. It counts line strobes inside each field. It counts fields across a low-speed accumulation. It also drives a write-enable flag that tells a downstream frame store which fields carry fresh sensor data. The analog pulse shapes and the pixel-clock edge placement belong to other logic. This block only issues one-cycle requests that mark the line or field concerned.

One 9-bit load value L serves two purposes. Call the gap between the all-ones code and the load value S, so S = 0x1FF − L. In high-speed mode, S is the number of lines discharged at the start of each field, so exposure shortens as S grows. In low-speed mode, 2·S is the number of fields that pass between readouts. The mode, load value, video standard and accumulation type are all sampled on the field strobe and held for the whole field.

Top module: `es_shutter_timer`

## Requirements
- R1: The 2-bit `shut_mode` code is 00 flickerless, 01 high-speed, 10 low-speed, 11 off. With the shutter off, every field starts with a readout, no discharge request is issued, and `wen` is high.
- R2: In high-speed mode, a `dis_req` pulse follows each of the first S = 0x1FF − L line strobes of a field, one cycle after each strobe. No pulse follows the remaining lines. A line strobe in the same cycle as the field strobe is not counted as a line.
- R3: The high-speed discharge count is capped at lines-per-field − 1, which is 261 when `std_pal` = 0 and 311 when `std_pal` = 1.
- R4: Flickerless mode discharges a fixed 105 lines per field with `std_pal` = 0, and 182 lines with `std_pal` = 1. The load value is not used.
- R5: In low-speed mode with field accumulation (`frame_acc` = 0), a readout occurs on every N-th field, where N = 2·S. The first low-speed field after reset, or after any other mode, is a readout field, and the field counter reloads at each readout. No discharge is requested in this mode.
- R6: In low-speed mode, the forbidden load value 0x1FF is treated as N = 2.
- R7: In low-speed field-accumulation mode, `wen` is high exactly during the fields that begin with a readout. In every other configuration, `wen` is high from the first field strobe on.
- R8: With `frame_acc` = 1, the low-speed settings have no effect: every field reads out, `wen` stays high, and no discharge is requested.
- R9: While `rd_en` is low at a field strobe, `rd_req` stays low for that field. The field counter and `wen` advance exactly as they would with `rd_en` high.
- R10: Changes to `load_val`, `shut_mode`, `std_pal` or `frame_acc` take effect only at the next field strobe. `wen` changes only in the cycle after a field strobe.
- R11: `rd_req` is a one-cycle pulse, issued one cycle after a field strobe. After reset, `rd_req`, `dis_req` and `wen` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_stb | input | 1 | One-cycle pulse per horizontal line |
| field_stb | input | 1 | One-cycle pulse at each field start |
| load_val | input | LOAD_W | Shutter load value L |
| shut_mode | input | 2 | Shutter mode code (R1) |
| std_pal | input | 1 | 0: 262-line standard, 1: 312-line standard |
| frame_acc | input | 1 | 0: field accumulation, 1: frame accumulation |
| rd_en | input | 1 | Readout enable; low suppresses the readout request |
| dis_req | output | 1 | Substrate discharge request for the current line |
| rd_req | output | 1 | Readout gate request for the current field |
| wen | output | 1 | Write-enable: field holds freshly read data |

## Verification
The bench builds the block with its default parameters: a 9-bit load value, a 10-bit line counter, 262 and 312 lines per field, and flickerless discharge counts of 105 and 182. These are small enough for full-length fields, so the bench can reach the clamp at 261 and 311 lines, which occurs when L = 0. The low-speed periods tested are N = 2 and N = 4, which show both the reload and the forbidden-value fallback within a handful of short fields. The bench also changes settings in the middle of a field and holds the readout enable low across a full accumulation cycle.

// File: rtl/es_pkg.sv
package es_pkg;

    typedef enum logic [1:0] {
        SM_FLICKERLESS = 2'b00,
        SM_HIGH        = 2'b01,
        SM_LOW         = 2'b10,
        SM_OFF         = 2'b11
    } shut_mode_e;

endpackage

// File: rtl/es_cfg_calc.sv
module es_cfg_calc #(
    parameter int LOAD_W   = 9,
    parameter int LINE_W   = 10,
    parameter int FCNT_W   = 10,
    parameter int LPF_NTSC = 262,
    parameter int LPF_PAL  = 312,
    parameter int FLK_NTSC = 105,
    parameter int FLK_PAL  = 182
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              field_stb,
    input  logic [LOAD_W-1:0] load_val,
    input  logic [1:0]        shut_mode,
    input  logic              std_pal,
    input  logic              frame_acc,
    output logic [LINE_W-1:0] act_dis_lines,
    output logic              nxt_lowfld,
    output logic [FCNT_W-1:0] nxt_period
);
    import es_pkg::*;

    localparam logic [LOAD_W-1:0] LOAD_MAX = '1;
    localparam logic [LINE_W-1:0] LPF_N_M1 = LINE_W'(LPF_NTSC - 1);
    localparam logic [LINE_W-1:0] LPF_P_M1 = LINE_W'(LPF_PAL - 1);
    localparam logic [LINE_W-1:0] FLK_N    = LINE_W'(FLK_NTSC);
    localparam logic [LINE_W-1:0] FLK_P    = LINE_W'(FLK_PAL);

    typedef struct packed {
        logic [LINE_W-1:0] dis_lines;
    } cfg_st_t;

    cfg_st_t           cfg_d, cfg_q;
    shut_mode_e        mode_in;
    logic [LOAD_W-1:0] span;
    logic [LINE_W-1:0] span_w;
    logic [LINE_W-1:0] lpf_m1;
    logic [LINE_W-1:0] hs_lines;
    logic [LINE_W-1:0] new_lines;

    always_comb begin
        mode_in  = shut_mode_e'(shut_mode);
        span     = LOAD_MAX - load_val;
        span_w   = LINE_W'(span);
        lpf_m1   = std_pal ? LPF_P_M1 : LPF_N_M1;
        // high-speed count never exceeds one line short of a full field
        hs_lines = (span_w > lpf_m1) ? lpf_m1 : span_w;

        unique case (mode_in)
            SM_HIGH:        new_lines = hs_lines;
            SM_FLICKERLESS: new_lines = std_pal ? FLK_P : FLK_N;
            default:        new_lines = '0;
        endcase

        // low-speed period: 2*S fields, forbidden S==0 falls back to 2
        nxt_lowfld = (mode_in == SM_LOW) && !frame_acc;
        nxt_period = (span == '0) ? FCNT_W'(2) : FCNT_W'({span, 1'b0});

        cfg_d = cfg_q;
        if (field_stb) begin
            cfg_d.dis_lines = new_lines;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign act_dis_lines = cfg_q.dis_lines;

endmodule

// File: rtl/es_line_gate.sv
module es_line_gate #(
    parameter int LINE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              field_stb,
    input  logic              line_stb,
    input  logic [LINE_W-1:0] dis_lines,
    output logic              dis_req
);
    localparam logic [LINE_W-1:0] LCNT_MAX = '1;

    typedef struct packed {
        logic [LINE_W-1:0] lcnt;
        logic              dis;
    } lg_st_t;

    lg_st_t lg_d, lg_q;

    always_comb begin
        lg_d     = lg_q;
        lg_d.dis = 1'b0;
        if (field_stb) begin
            lg_d.lcnt = '0;
        end else if (line_stb) begin
            lg_d.dis = (lg_q.lcnt < dis_lines);
            if (lg_q.lcnt != LCNT_MAX) begin
                lg_d.lcnt = lg_q.lcnt + LINE_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lg_q <= '0;
        end else begin
            lg_q <= lg_d;
        end
    end

    assign dis_req = lg_q.dis;

endmodule

// File: rtl/es_field_seq.sv
module es_field_seq #(
    parameter int FCNT_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              field_stb,
    input  logic              rd_en,
    input  logic              lowfld,
    input  logic [FCNT_W-1:0] period,
    output logic              rd_req,
    output logic              wen
);
    typedef struct packed {
        logic [FCNT_W-1:0] fcnt;
        logic              rd;
        logic              wen;
    } fs_st_t;

    fs_st_t fs_d, fs_q;
    logic   rd_field;

    always_comb begin
        fs_d     = fs_q;
        fs_d.rd  = 1'b0;
        rd_field = 1'b0;
        if (field_stb) begin
            if (lowfld) begin
                rd_field  = (fs_q.fcnt <= FCNT_W'(1));
                fs_d.fcnt = rd_field ? period : (fs_q.fcnt - FCNT_W'(1));
                fs_d.wen  = rd_field;
            end else begin
                rd_field  = 1'b1;
                fs_d.fcnt = '0;
                fs_d.wen  = 1'b1;
            end
            fs_d.rd = rd_field && rd_en;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fs_q <= '0;
        end else begin
            fs_q <= fs_d;
        end
    end

    assign rd_req = fs_q.rd;
    assign wen    = fs_q.wen;

endmodule

// File: rtl/es_shutter_timer.sv
module es_shutter_timer #(
    parameter int LOAD_W   = 9,
    parameter int LINE_W   = 10,
    parameter int LPF_NTSC = 262,
    parameter int LPF_PAL  = 312,
    parameter int FLK_NTSC = 105,
    parameter int FLK_PAL  = 182
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_stb,
    input  logic              field_stb,
    input  logic [LOAD_W-1:0] load_val,
    input  logic [1:0]        shut_mode,
    input  logic              std_pal,
    input  logic              frame_acc,
    input  logic              rd_en,
    output logic              dis_req,
    output logic              rd_req,
    output logic              wen
);
    localparam int FCNT_W = LOAD_W + 1;

    logic [LINE_W-1:0] act_dis_lines;
    logic              nxt_lowfld;
    logic [FCNT_W-1:0] nxt_period;

    es_cfg_calc #(
        .LOAD_W  (LOAD_W),
        .LINE_W  (LINE_W),
        .FCNT_W  (FCNT_W),
        .LPF_NTSC(LPF_NTSC),
        .LPF_PAL (LPF_PAL),
        .FLK_NTSC(FLK_NTSC),
        .FLK_PAL (FLK_PAL)
    ) u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .field_stb    (field_stb),
        .load_val     (load_val),
        .shut_mode    (shut_mode),
        .std_pal      (std_pal),
        .frame_acc    (frame_acc),
        .act_dis_lines(act_dis_lines),
        .nxt_lowfld   (nxt_lowfld),
        .nxt_period   (nxt_period)
    );

    es_line_gate #(
        .LINE_W(LINE_W)
    ) u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .field_stb(field_stb),
        .line_stb (line_stb),
        .dis_lines(act_dis_lines),
        .dis_req  (dis_req)
    );

    es_field_seq #(
        .FCNT_W(FCNT_W)
    ) u_field (
        .clk      (clk),
        .rst_n    (rst_n),
        .field_stb(field_stb),
        .rd_en    (rd_en),
        .lowfld   (nxt_lowfld),
        .period   (nxt_period),
        .rd_req   (rd_req),
        .wen      (wen)
    );

endmodule

// File: rtl/es_shutter_chk.sv
module es_shutter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       line_stb,
    input logic       field_stb,
    input logic [1:0] shut_mode,
    input logic       frame_acc,
    input logic       rd_en,
    input logic       dis_req,
    input logic       rd_req,
    input logic       wen
);
    import es_pkg::*;

    logic       live_q;
    logic [1:0] mode_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            live_q <= 1'b0;
            mode_q <= SM_OFF;
        end else begin
            live_q <= 1'b1;
            if (field_stb) begin
                mode_q <= shut_mode;
            end
        end
    end

    AST_RD_AFTER_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && rd_req) |-> $past(field_stb)); // R11

    AST_RD_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && rd_req) |-> $past(rd_en)); // R9

    AST_DIS_AFTER_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && dis_req) |-> ($past(line_stb) && !$past(field_stb))); // R2

    AST_DIS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        dis_req |-> (mode_q == SM_HIGH || mode_q == SM_FLICKERLESS)); // R1

    AST_WEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && !$past(field_stb)) |-> $stable(wen)); // R10

    AST_FRAME_WEN: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(field_stb) && $past(frame_acc)) |-> wen); // R8

    AST_RD_DIS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req && dis_req)); // R2

endmodule

bind es_shutter_timer es_shutter_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_stb (line_stb),
    .field_stb(field_stb),
    .shut_mode(shut_mode),
    .frame_acc(frame_acc),
    .rd_en    (rd_en),
    .dis_req  (dis_req),
    .rd_req   (rd_req),
    .wen      (wen)
);

// File: tb/tb_es_shutter_timer.sv
module tb_es_shutter_timer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_stb = 1'b0;
    logic       field_stb = 1'b0;
    logic [8:0] load_val = 9'h1FF;
    logic [1:0] shut_mode = 2'b11;
    logic       std_pal = 1'b0;
    logic       frame_acc = 1'b0;
    logic       rd_en = 1'b1;
    logic       dis_req, rd_req, wen;

    int n_chk = 0;
    int n_fail = 0;

    localparam logic [1:0] M_FLK = 2'b00, M_HIGH = 2'b01, M_LOW = 2'b10, M_OFF = 2'b11;

    always #5 clk = ~clk;

    es_shutter_timer dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_stb (line_stb),
        .field_stb(field_stb),
        .load_val (load_val),
        .shut_mode(shut_mode),
        .std_pal  (std_pal),
        .frame_acc(frame_acc),
        .rd_en    (rd_en),
        .dis_req  (dis_req),
        .rd_req   (rd_req),
        .wen      (wen)
    );

    task automatic chk(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    // one field: strobe, then nlines line strobes two cycles apart
    task automatic do_field(input int nlines, input bit coincide, input int chg_at,
                            input logic [8:0] chg_load, output int n_dis,
                            output int contig, output int rd_seen, output int wen_seen);
        n_dis  = 0;
        contig = 1;
        @(negedge clk);
        field_stb = 1'b1;
        line_stb  = coincide;
        @(negedge clk);
        field_stb = 1'b0;
        line_stb  = 1'b0;
        rd_seen   = int'(rd_req);
        wen_seen  = int'(wen);
        if (dis_req) contig = 0;
        @(negedge clk);
        if (rd_req) rd_seen = 2;
        for (int i = 0; i < nlines; i++) begin
            if (i == chg_at) load_val = chg_load;
            line_stb = 1'b1;
            @(negedge clk);
            line_stb = 1'b0;
            if (dis_req) begin
                if (n_dis != i) contig = 0;
                n_dis++;
            end
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        chk("R11 reset rd_req", int'(rd_req), 0);
        chk("R11 reset dis_req", int'(dis_req), 0);
        chk("R11 reset wen", int'(wen), 0);
    endtask

    task automatic t_off();
        int nd, ct, rd, we;
        shut_mode = M_OFF; std_pal = 1'b0; load_val = 9'h100;
        do_field(262, 1'b0, -1, 9'h0, nd, ct, rd, we);
        chk("R1 off readout", rd, 1);
        chk("R1 off no discharge", nd, 0);
        chk("R1 off wen", we, 1);
    endtask

    task automatic t_high();
        int nd, ct, rd, we;
        shut_mode = M_HIGH; load_val = 9'h1F0;
        do_field(40, 1'b1, -1, 9'h0, nd, ct, rd, we);
        chk("R2 high discharge count", nd, 15);
        chk("R2 high first lines only", ct, 1);
        chk("R11 high readout pulse", rd, 1);
    endtask

    task automatic t_clamp();
        int nd, ct, rd, we;
        shut_mode = M_HIGH; load_val = 9'h000; std_pal = 1'b0;
        do_field(262, 1'b0, -1, 9'h0, nd, ct, rd, we);
        chk("R3 clamp 262-line", nd, 261);
        std_pal = 1'b1;
        do_field(312, 1'b0, -1, 9'h0, nd, ct, rd, we);
        chk("R3 clamp 312-line", nd, 311);
        std_pal = 1'b0;
    endtask

    task automatic t_flk();
        int nd, ct, rd, we;
        shut_mode = M_FLK; load_val = 9'h1FE; std_pal = 1'b0;
        do_field(262, 1'b0, -1, 9'h0, nd, ct, rd, we);
        chk("R4 flickerless 262-line", nd, 105);
        chk("R4 flickerless contiguous", ct, 1);
        std_pal = 1'b1;
        do_field(312, 1'b0, -1, 9'h0, nd, ct, rd, we);
        chk("R4 flickerless 312-line", nd, 182);
        std_pal = 1'b0;
    endtask

    task automatic clear_field();
        int nd, ct, rd, we;
        shut_mode = M_OFF;
        do_field(10, 1'b0, -1, 9'h0, nd, ct, rd, we);
    endtask

    task automatic t_low();
        int nd, ct, rd, we;
        clear_field();
        shut_mode = M_LOW; load_val = 9'h1FD;
        for (int f = 0; f < 9; f++) begin
            do_field(10, 1'b0, -1, 9'h0, nd, ct, rd, we);
            chk($sformatf("R5 low N=4 field %0d readout", f), rd, (f % 4 == 0) ? 1 : 0);
            chk($sformatf("R7 low N=4 field %0d wen", f), we, (f % 4 == 0) ? 1 : 0);
            chk("R5 low no discharge", nd, 0);
        end
    endtask

    task automatic t_low_min();
        int nd, ct, rd, we;
        clear_field();
        shut_mode = M_LOW; load_val = 9'h1FF;
        for (int f = 0; f < 5; f++) begin
            do_field(10, 1'b0, -1, 9'h0, nd, ct, rd, we);
            chk($sformatf("R6 forbidden load field %0d readout", f), rd, (f % 2 == 0) ? 1 : 0);
        end
    endtask

    task automatic t_frame();
        int nd, ct, rd, we;
        clear_field();
        frame_acc = 1'b1; shut_mode = M_LOW; load_val = 9'h1FD;
        for (int f = 0; f < 3; f++) begin
            do_field(10, 1'b0, -1, 9'h0, nd, ct, rd, we);
            chk("R8 frame readout each field", rd, 1);
            chk("R8 frame wen high", we, 1);
            chk("R8 frame no discharge", nd, 0);
        end
        frame_acc = 1'b0;
    endtask

    task automatic t_rden();
        int nd, ct, rd, we;
        clear_field();
        shut_mode = M_LOW; load_val = 9'h1FE; rd_en = 1'b0;
        for (int f = 0; f < 4; f++) begin
            do_field(10, 1'b0, -1, 9'h0, nd, ct, rd, we);
            chk("R9 readout suppressed", rd, 0);
            chk($sformatf("R9 wen field %0d", f), we, (f % 2 == 0) ? 1 : 0);
        end
        rd_en = 1'b1;
        do_field(10, 1'b0, -1, 9'h0, nd, ct, rd, we);
        chk("R9 readout resumes in phase", rd, 1);
        chk("R9 wen in phase", we, 1);
    endtask

    task automatic t_midchg();
        int nd, ct, rd, we;
        shut_mode = M_HIGH; load_val = 9'h1F0;
        do_field(40, 1'b0, 3, 9'h1E0, nd, ct, rd, we);
        chk("R10 mid-field load ignored", nd, 15);
        do_field(40, 1'b0, -1, 9'h0, nd, ct, rd, we);
        chk("R10 new load at next field", nd, 31);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_off();
        t_high();
        t_clamp();
        t_flk();
        t_low();
        t_low_min();
        t_frame();
        t_rden();
        t_midchg();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule